// File: doc/BRIEF.md
# Dual-Channel Shadowed Configuration Register Bank

This block is the byte-wide configuration store of a two-channel data converter. A host reaches it through a plain register port that carries an address, write data, a write strobe and a read strobe, and it returns read data one clock later. Some registers are global and have a single copy. Others are local, which means each channel has its own copy. A channel-index register chooses which channel's copy a local access reaches.

A group of registers is double-buffered. A host write to one of these registers changes only a pending copy. The register's active value, which drives the converter, does not change. A write to the transfer address commits every pending copy of both channels in one clock. The transfer bit does not stay set and always reads back as zero.

The active value of every implemented register is presented on two wide output buses, one per channel. Byte k of each bus is table slot k. For a global register, both buses carry the same byte.

Top module: `cfgbank_top`

## Requirements
- R1: After reset, the implemented registers hold their defaults. The table slots are 0:0x00, 1:0x01, 2:0x02, 3:0x05, 4:0x08, 5:0x0D, 6:0x14, 7:0x18, 8:0x2A and 9:0x30. Address 0x00 resets to 0x18, 0x05 to 0x03, 0x14 to 0x01 and 0x18 to 0xC0. Every other register resets to 0x00.
- R2: A read of an address outside the table (0x03 or 0x40, for example) returns 0x00. A write to such an address changes no active output.
- R3: A write to a double-buffered address (0x08 through 0x18, or 0x30) leaves the active output unchanged. A read of that address returns the newly written value.
- R4: A write to 0xFF with bit 0 set copies every pending value of both channels to the active outputs, which show the result after the next rising edge. A write to 0xFF with bit 0 clear commits nothing. A read of 0xFF returns 0x00.
- R5: In register 0x05, bit 0 enables channel A and bit 1 enables channel B. A write to a local register (0x08, 0x14, 0x2A, 0x30) updates the copy of each enabled channel. If neither bit is set, no copy is updated.
- R6: A read of a local register returns the channel B copy only when 0x05 equals 0x02. In every other case it returns the channel A copy.
- R7: Global registers (0x00, 0x01, 0x02, 0x05, 0x0D, 0x18) are written and read regardless of 0x05, and both output buses carry the same value for them.
- R8: Bits outside each register's implemented set read as 0 and are 0 on the outputs. The implemented sets are: 0x00 bits 6..1, 0x02 bits 3..0, 0x05 bits 1..0, 0x0D bits 5..0, 0x14 bits 3..0, 0x18 bits 7, 6, 1 and 0. All other registers implement every bit.
- R9: A write to a register that is not double-buffered (0x00, 0x01, 0x02, 0x05, 0x2A) shows on the active outputs after the next rising edge.
- R10: Read data is registered on the rising edge that samples the read strobe. It holds its value while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| act_a | output | 80 | Channel A active values, byte k = slot k |
| act_b | output | 80 | Channel B active values, byte k = slot k |

## Verification
Every result of this block is due exactly one rising edge after its stimulus:
- a direct write appears on the active buses;
- a transfer write moves all pending values to the active buses;
- a read strobe loads rdata.

The reset release reaches the internal logic two edges after rst_n rises. The bench therefore waits several cycles before its first access.

Each access task drives its inputs on a falling edge and removes them on the next falling edge. It samples outputs at that second falling edge, which lies half a period after the single edge on which the result is due. Checks of pending values read them back through the port, and the active buses are compared in the same half-period window.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  localparam int DW = 8;
  localparam int AW = 8;
  localparam int NCH = 2;
  localparam int NREG = 10;
  localparam int CHIDX_SLOT = 3;
  localparam logic [AW-1:0] XFER_ADDR = 8'hFF;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] mask;
    logic [DW-1:0] rstv;
    logic          is_local;
  } slot_t;

  function automatic slot_t slot_info(input int idx);
    slot_t s;
    case (idx)
      0:       s = '{addr: 8'h00, mask: 8'h7E, rstv: 8'h18, is_local: 1'b0};
      1:       s = '{addr: 8'h01, mask: 8'hFF, rstv: 8'h00, is_local: 1'b0};
      2:       s = '{addr: 8'h02, mask: 8'h0F, rstv: 8'h00, is_local: 1'b0};
      3:       s = '{addr: 8'h05, mask: 8'h03, rstv: 8'h03, is_local: 1'b0};
      4:       s = '{addr: 8'h08, mask: 8'hFF, rstv: 8'h00, is_local: 1'b1};
      5:       s = '{addr: 8'h0D, mask: 8'h3F, rstv: 8'h00, is_local: 1'b0};
      6:       s = '{addr: 8'h14, mask: 8'h0F, rstv: 8'h01, is_local: 1'b1};
      7:       s = '{addr: 8'h18, mask: 8'hC3, rstv: 8'hC0, is_local: 1'b0};
      8:       s = '{addr: 8'h2A, mask: 8'hFF, rstv: 8'h00, is_local: 1'b1};
      default: s = '{addr: 8'h30, mask: 8'hFF, rstv: 8'h00, is_local: 1'b1};
    endcase
    return s;
  endfunction

  // double-buffered window: 0x08..0x18 plus 0x30
  function automatic logic is_shadowed(input logic [AW-1:0] a);
    return ((a >= 8'h08) && (a <= 8'h18)) || (a == 8'h30);
  endfunction

endpackage

// File: rtl/cfgbank_decode.sv
module cfgbank_decode
  import cfgbank_pkg::*;
(
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic            xfer_bit,
  output logic [NREG-1:0] addr_hit,
  output logic            commit
);

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    localparam slot_t S = slot_info(i);
    assign addr_hit[i] = (addr == S.addr);
  end

  assign commit = wr_en && (addr == XFER_ADDR) && xfer_bit;

endmodule

// File: rtl/cfgbank_slot.sv
module cfgbank_slot
  import cfgbank_pkg::*;
#(
  parameter logic [DW-1:0] MASK      = 8'hFF,
  parameter logic [DW-1:0] RSTV      = 8'h00,
  parameter bit            IS_LOCAL  = 1'b0,
  parameter bit            IS_SHADOW = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hit,
  input  logic [DW-1:0]   wdata,
  input  logic [NCH-1:0]  ch_sel,
  input  logic            commit,
  output logic [DW-1:0]   view_a,
  output logic [DW-1:0]   view_b,
  output logic [DW-1:0]   act_a,
  output logic [DW-1:0]   act_b
);

  localparam int NCOPY = IS_LOCAL ? NCH : 1;

  logic [DW-1:0] act_q  [NCOPY];
  logic [DW-1:0] act_d  [NCOPY];
  logic [DW-1:0] shd_q  [NCOPY];
  logic [DW-1:0] shd_d  [NCOPY];
  logic          we     [NCOPY];

  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    assign we[c] = wr_hit & (IS_LOCAL ? ch_sel[c] : 1'b1);

    always_comb begin
      shd_d[c] = we[c] ? (wdata & MASK) : shd_q[c];
      act_d[c] = IS_SHADOW ? (commit ? shd_q[c] : act_q[c]) : shd_d[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q[c] <= RSTV;
      else        act_q[c] <= act_d[c];
    end

    if (IS_SHADOW) begin : g_pend
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shd_q[c] <= RSTV;
        else        shd_q[c] <= shd_d[c];
      end
    end else begin : g_direct
      assign shd_q[c] = act_q[c];
    end
  end

  assign view_a = shd_q[0];
  assign view_b = shd_q[NCOPY-1];
  assign act_a  = act_q[0];
  assign act_b  = act_q[NCOPY-1];

endmodule

// File: rtl/cfgbank_rdmux.sv
module cfgbank_rdmux
  import cfgbank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [NREG-1:0]    addr_hit,
  input  logic [NCH-1:0]     ch_sel,
  input  logic [NREG*DW-1:0] view_a,
  input  logic [NREG*DW-1:0] view_b,
  output logic [DW-1:0]      rdata
);

  logic [DW-1:0] rd_sel;
  logic [DW-1:0] rdata_d;
  logic          pick_b;

  assign pick_b = (ch_sel == 2'b10);

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr_hit[i]) rd_sel = pick_b ? view_b[i*DW +: DW] : view_a[i*DW +: DW];
    end
    rdata_d = rd_en ? rd_sel : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  input  logic               wr_en,
  input  logic               rd_en,
  output logic [DW-1:0]      rdata,
  output logic [NREG*DW-1:0] act_a,
  output logic [NREG*DW-1:0] act_b
);

  logic [1:0]         rst_sync;
  logic               rst_i;
  logic [NREG-1:0]    addr_hit;
  logic               commit;
  logic [NCH-1:0]     ch_sel;
  logic [NREG*DW-1:0] view_a;
  logic [NREG*DW-1:0] view_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  cfgbank_decode u_dec (
    .addr     (addr),
    .wr_en    (wr_en),
    .xfer_bit (wdata[0]),
    .addr_hit (addr_hit),
    .commit   (commit)
  );

  assign ch_sel = act_a[CHIDX_SLOT*DW +: NCH];

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam slot_t S = slot_info(i);
    cfgbank_slot #(
      .MASK      (S.mask),
      .RSTV      (S.rstv),
      .IS_LOCAL  (S.is_local),
      .IS_SHADOW (is_shadowed(S.addr))
    ) u_slot (
      .clk    (clk),
      .rst_n  (rst_i),
      .wr_hit (wr_en & addr_hit[i]),
      .wdata  (wdata),
      .ch_sel (ch_sel),
      .commit (commit),
      .view_a (view_a[i*DW +: DW]),
      .view_b (view_b[i*DW +: DW]),
      .act_a  (act_a[i*DW +: DW]),
      .act_b  (act_b[i*DW +: DW])
    );
  end

  cfgbank_rdmux u_rd (
    .clk      (clk),
    .rst_n    (rst_i),
    .rd_en    (rd_en),
    .addr_hit (addr_hit),
    .ch_sel   (ch_sel),
    .view_a   (view_a),
    .view_b   (view_b),
    .rdata    (rdata)
  );

endmodule

// File: rtl/cfgbank_checker.sv
module cfgbank_checker
  import cfgbank_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      addr,
  input logic [DW-1:0]      wdata,
  input logic               wr_en,
  input logic               rd_en,
  input logic [DW-1:0]      rdata,
  input logic [NREG*DW-1:0] act_a,
  input logic [NREG*DW-1:0] act_b
);

  a_r2_unimpl_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == 8'h03 || addr == 8'h40) |=> rdata == 8'h00);

  a_r3_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 8'h08 |=> $stable(act_a[39:32]) && $stable(act_b[39:32]));

  a_r4_xfer_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 8'hFF |=> rdata == 8'h00);

  a_r4_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 8'hFF && wdata[0] &&
    $past(wr_en && addr == 8'h08 && act_a[25:24] == 2'b11)
    |=> act_a[39:32] == $past(wdata, 2) && act_b[39:32] == $past(wdata, 2));

  a_r5_steer_a_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 8'h2A && act_a[25:24] == 2'b01 |=> $stable(act_b[71:64]));

  a_r8_unused_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 8'h00 |=> rdata[7] == 1'b0 && rdata[0] == 1'b0);

endmodule

bind cfgbank_top cfgbank_checker u_chk (
  .clk   (clk),
  .rst_n (rst_i),
  .addr  (addr),
  .wdata (wdata),
  .wr_en (wr_en),
  .rd_en (rd_en),
  .rdata (rdata),
  .act_a (act_a),
  .act_b (act_b)
);

// File: tb/cfgbank_top_test.sv
module cfgbank_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic [7:0]  wdata;
  logic        wr_en;
  logic        rd_en;
  logic [7:0]  rdata;
  logic [79:0] act_a;
  logic [79:0] act_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cfgbank_top uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .act_a(act_a), .act_b(act_b)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] ba(input int k); return act_a[k*8 +: 8]; endfunction
  function automatic logic [7:0] bb(input int k); return act_b[k*8 +: 8]; endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    logic [7:0] exp [10] = '{8'h18, 8'h00, 8'h00, 8'h03, 8'h00, 8'h00, 8'h01, 8'hC0, 8'h00, 8'h00};
    logic [7:0] adr [10] = '{8'h00, 8'h01, 8'h02, 8'h05, 8'h08, 8'h0D, 8'h14, 8'h18, 8'h2A, 8'h30};
    chk("R1 rdata after reset", rdata, 8'h00);
    for (int k = 0; k < 10; k++) begin
      chk("R1 act_a default", ba(k), exp[k]);
      chk("R1 act_b default", bb(k), exp[k]);
      rd(adr[k], d);
      chk("R1 read default", d, exp[k]);
    end
  endtask

  task automatic t_unimpl();
    logic [7:0] d;
    logic [79:0] sa, sb;
    sa = act_a; sb = act_b;
    wr(8'h03, 8'hFF);
    wr(8'h40, 8'hA5);
    n_chk++;
    if (act_a !== sa || act_b !== sb) begin
      n_fail++;
      $display("FAIL R2 outputs changed: got %h/%h expected %h/%h", act_a, act_b, sa, sb);
    end
    rd(8'h03, d); chk("R2 read 0x03", d, 8'h00);
    rd(8'h40, d); chk("R2 read 0x40", d, 8'h00);
  endtask

  task automatic t_direct_and_mask();
    logic [7:0] d;
    wr(8'h00, 8'hFF);
    chk("R9 R8 act_a 0x00", ba(0), 8'h7E);
    rd(8'h00, d); chk("R8 read 0x00", d, 8'h7E);
    wr(8'h02, 8'hF5);
    chk("R8 act 0x02", ba(2), 8'h05);
    // R10 read data holds while strobe low
    repeat (3) @(negedge clk);
    chk("R10 rdata hold", rdata, 8'h7E);
  endtask

  task automatic t_shadow();
    logic [7:0] d;
    wr(8'h08, 8'h5A);
    chk("R3 act_a 0x08 held", ba(4), 8'h00);
    chk("R3 act_b 0x08 held", bb(4), 8'h00);
    rd(8'h08, d); chk("R3 read pending 0x08", d, 8'h5A);
    wr(8'h18, 8'hFF);
    chk("R3 act 0x18 held", ba(7), 8'hC0);
    rd(8'h18, d); chk("R3 R8 read pending 0x18", d, 8'hC3);
    wr(8'hFF, 8'h00);
    chk("R4 no commit on bit0 clear", ba(4), 8'h00);
  endtask

  task automatic t_transfer();
    logic [7:0] d;
    wr(8'hFF, 8'h01);
    chk("R4 act_a 0x08", ba(4), 8'h5A);
    chk("R4 act_b 0x08", bb(4), 8'h5A);
    chk("R4 act 0x18", ba(7), 8'hC3);
    rd(8'hFF, d); chk("R4 read 0xFF", d, 8'h00);
  endtask

  task automatic t_steer();
    logic [7:0] d;
    wr(8'h05, 8'h01);
    chk("R9 idx applied", ba(3), 8'h01);
    wr(8'h2A, 8'h11);
    chk("R5 A-only act_a", ba(8), 8'h11);
    chk("R5 A-only act_b", bb(8), 8'h00);
    wr(8'h30, 8'h77);
    wr(8'h05, 8'h02);
    wr(8'h2A, 8'h22);
    chk("R5 B-only act_a", ba(8), 8'h11);
    chk("R5 B-only act_b", bb(8), 8'h22);
    rd(8'h2A, d); chk("R6 read B copy", d, 8'h22);
    wr(8'h30, 8'h88);
    wr(8'h01, 8'hA5);
    chk("R7 global act_a", ba(1), 8'hA5);
    chk("R7 global act_b", bb(1), 8'hA5);
    rd(8'h01, d); chk("R7 global read", d, 8'hA5);
    wr(8'hFF, 8'h01);
    chk("R4 R5 commit A 0x30", ba(9), 8'h77);
    chk("R4 R5 commit B 0x30", bb(9), 8'h88);
    wr(8'h05, 8'h03);
    rd(8'h2A, d); chk("R6 both reads A", d, 8'h11);
    wr(8'h05, 8'h00);
    rd(8'h2A, d); chk("R6 none reads A", d, 8'h11);
    wr(8'h2A, 8'h33);
    chk("R5 none act_a", ba(8), 8'h11);
    chk("R5 none act_b", bb(8), 8'h22);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unimpl();
    t_direct_and_mask();
    t_shadow();
    t_transfer();
    t_steer();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule